// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that copies data between memory and an I/O device. Every transfer uses two bus cycles. The first reads from the source address. The second writes the value it read to the destination address. Software sets up a source address, a destination address, a 16-bit byte count and a control word through a small register port. It then reads and clears a status word through the same port.

An external request line starts the work. In cycle-steal mode each rising edge of the request causes exactly one read/write pair. In continuous mode one rising edge runs pairs back to back until the count is exhausted. Each side has its own increment flag and its own size, byte or halfword, so the same block serves memory-to-device, device-to-memory and width-converting copies. When the count reaches zero the channel flags completion and, if enabled, holds an interrupt.

Top module: `dma_channel`

## Requirements
- R1: Each transfer is a read at the source address followed by a write of the read data at the destination address. `bus_half` gives the size of each phase: 1 means halfword, 0 means byte. A byte read takes lane [7:0] and zero-extends it. All bus outputs hold steady while `bus_valid` is high and `bus_ready` is low.
- R2: A request starts a transfer only on a rising edge of `xfer_req`, and only when all of these hold: the channel is idle, control bit 0 (request enable) is 1, and the count is nonzero. Any other request is ignored.
- R3: When control bit 1 (cycle steal) is 1, each accepted request edge performs exactly one read/write pair, and the channel then returns to idle.
- R4: When control bit 1 is 0, one accepted edge performs pairs back to back until the count reaches zero, or until request enable is found cleared after a write.
- R5: Control bits 2 and 3 make the source and destination addresses increment after each write. The step is 1 for byte size and 2 for halfword size, taken from that side's own size bit (control bit 4 for the source, bit 5 for the destination). A side whose increment bit is 0 keeps its address fixed.
- R6: The byte count (register 2) drops by the destination size after each acknowledged write, stops at zero rather than wrapping, and reads back zero once the run has completed.
- R7: Status bit 0 (DONE) is set by the clock edge that takes the acknowledge of the final write. Status bit 1 (BUSY) is 1 from the accepted request until the write acknowledge that ends the run.
- R8: `irq` equals DONE while control bit 6 (interrupt enable) is 1, and stays high until DONE is cleared.
- R9: Writing register 4 with bit 0 set clears DONE and aborts any transfer in progress, which returns the channel to idle. If such a write falls in the same cycle as the final write acknowledge, the abort wins: DONE stays 0 and the count is not updated.
- R10: While BUSY is 1, writes to the source (register 0), destination (register 1) and count (register 2) registers have no effect.
- R11: After reset all registers and status bits read 0, `bus_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 status |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the register at `reg_addr` |
| xfer_req | input | 1 | External transfer request |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 for the write phase, 0 for the read phase |
| bus_half | output | 1 | 1 for a halfword cycle, 0 for a byte cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data from the slave |
| bus_ready | input | 1 | Slave acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The final write acknowledge and a software abort can fall in the same clock cycle. These two events conflict: the acknowledge wants to set DONE and update the count, while the abort wants to clear DONE and send the channel to idle. The bench provokes this by taking manual control of the slave acknowledge. It raises `bus_ready` for the last write on the same falling edge where it drives the status-clear write, so both reach the same rising edge. It then judges the outcome at the ports: BUSY, DONE and `irq` must read 0 and the count must still show the undecremented value. A second run with the acknowledge alone must set DONE and zero the count.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          xfer_req,
  output logic          bus_valid,
  output logic          bus_we,
  output logic          bus_half,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ready,
  output logic          irq
);
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_CNT = 3'd2,
                         A_CTL = 3'd3, A_STS = 3'd4;
  localparam int CTLW = 7;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t             st;
  logic [AW-1:0]   src_q, dst_q;
  logic [CW-1:0]   cnt_q;
  logic [CTLW-1:0] ctrl_q;
  logic [15:0]     data_q;
  logic            done_q, req_q;

  wire req_en   = ctrl_q[0];
  wire steal    = ctrl_q[1];
  wire src_inc  = ctrl_q[2];
  wire dst_inc  = ctrl_q[3];
  wire src_half = ctrl_q[4];
  wire dst_half = ctrl_q[5];
  wire irq_en   = ctrl_q[6];

  wire busy  = (st != S_IDLE);
  wire abort = reg_wr && (reg_addr == A_STS) && reg_wdata[0];
  wire start = (st == S_IDLE) && xfer_req && !req_q && req_en && (cnt_q != '0) && !abort;

  wire [AW-1:0] src_step = !src_inc ? '0 : (src_half ? AW'(2) : AW'(1));
  wire [AW-1:0] dst_step = !dst_inc ? '0 : (dst_half ? AW'(2) : AW'(1));
  wire [CW-1:0] dec      = dst_half ? CW'(2) : CW'(1);
  wire [CW-1:0] cnt_next = (cnt_q > dec) ? cnt_q - dec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= xfer_req;
      if (abort) begin
        st     <= S_IDLE;
        done_q <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) st <= S_RD;
          S_RD: if (bus_ready) begin
            data_q <= src_half ? bus_rdata : {8'h00, bus_rdata[7:0]};
            st     <= S_WR;
          end
          S_WR: if (bus_ready) begin
            src_q <= src_q + src_step;
            dst_q <= dst_q + dst_step;
            cnt_q <= cnt_next;
            if (cnt_next == '0) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else if (steal || !req_en) begin
              st <= S_IDLE;
            end else begin
              st <= S_RD;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
      if (reg_wr) begin
        if (reg_addr == A_CTL) ctrl_q <= reg_wdata[CTLW-1:0];
        if (!busy) begin
          if (reg_addr == A_SRC) src_q <= reg_wdata;
          if (reg_addr == A_DST) dst_q <= reg_wdata;
          if (reg_addr == A_CNT) cnt_q <= reg_wdata[CW-1:0];
        end
      end
    end
  end

  assign bus_valid = busy;
  assign bus_we    = (st == S_WR);
  assign bus_addr  = bus_we ? dst_q : src_q;
  assign bus_half  = bus_we ? dst_half : src_half;
  assign bus_wdata = data_q;
  assign irq       = done_q && irq_en;

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = src_q;
      A_DST:   reg_rdata = dst_q;
      A_CNT:   reg_rdata = AW'(cnt_q);
      A_CTL:   reg_rdata = AW'(ctrl_q);
      A_STS:   reg_rdata = AW'({busy, done_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

module dma_channel_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          reg_wdata0,
  input logic          bus_valid,
  input logic          bus_we,
  input logic          bus_half,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          bus_ready,
  input logic          busy,
  input logic          done,
  input logic          steal,
  input logic [CW-1:0] cnt
);
  wire abort_w = reg_wr && (reg_addr == 3'd4) && reg_wdata0;

  assert_hold_while_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !reg_wr |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_we) && $stable(bus_half) && $stable(bus_wdata));

  assert_write_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_we && bus_ready && !reg_wr |=> bus_valid && bus_we);

  assert_one_pair_per_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    steal && bus_valid && bus_we && bus_ready && !reg_wr |=> !bus_valid);

  assert_count_never_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !reg_wr |=> cnt <= $past(cnt));

  assert_done_on_write_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_valid && bus_we && bus_ready));

  assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !busy && !done && !bus_valid);
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata0(reg_wdata[0]), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready), .busy(busy), .done(done_q), .steal(ctrl_q[1]),
  .cnt(cnt_q)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEV = 32'hF0;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic xfer_req = 0;
  logic bus_valid, bus_we, bus_half, bus_ready;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic irq;

  logic manual = 0, force_ack = 0, auto_ready = 0;
  logic [15:0] rdata_q = 0;
  int lat = 0, wcnt = 0, dev_n = 0, dev_rd = 0;
  int total = 0, bad = 0;
  logic [7:0] mem [0:255];
  logic [15:0] dev_log [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_ready = manual ? force_ack : auto_ready;
  assign bus_rdata = rdata_q;

  dma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst_n || manual) begin
      auto_ready = 0; wcnt = 0;
    end else if (auto_ready) begin
      auto_ready = 0; wcnt = 0;
    end else if (bus_valid) begin
      if (wcnt >= lat) begin
        auto_ready = 1;
        if (bus_we) begin
          if (bus_addr == DEV) begin
            dev_log[dev_n] = bus_half ? bus_wdata : {8'h00, bus_wdata[7:0]};
            dev_n++;
          end else begin
            mem[bus_addr[7:0]] = bus_wdata[7:0];
            if (bus_half) mem[bus_addr[7:0] + 8'd1] = bus_wdata[15:8];
          end
        end else if (bus_addr == DEV) begin
          rdata_q = 16'hB000 + 16'(dev_rd);
          dev_rd++;
        end else begin
          rdata_q = bus_half ? {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]}
                             : {8'hEE, mem[bus_addr[7:0]]};
        end
      end else wcnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); xfer_req = 1;
    @(negedge clk); xfer_req = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h2;
    while (s[1]) rd(3'd4, s);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk_eq("R11 register reset", v, 0);
    end
    chk_eq("R11 bus_valid reset", 32'(bus_valid), 0);
    chk_eq("R11 irq reset", 32'(irq), 0);
  endtask

  task automatic t_steal_m2d();
    logic [31:0] v;
    mem[8'h10] = 8'h11; mem[8'h11] = 8'h22; mem[8'h12] = 8'h33;
    dev_n = 0; lat = 1;
    wr(3'd0, 32'h10); wr(3'd1, DEV); wr(3'd2, 3); wr(3'd3, 32'h47);
    pulse(); wait_idle();
    chk_eq("R3 one pair per edge", 32'(dev_n), 1);
    rd(3'd2, v); chk_eq("R6 count after first byte", v, 2);
    rd(3'd4, v); chk_eq("R7 done not yet", v, 0);
    pulse(); wait_idle(); pulse(); wait_idle();
    chk_eq("R1 device byte 0", 32'(dev_log[0]), 32'h11);
    chk_eq("R1 device byte 1", 32'(dev_log[1]), 32'h22);
    chk_eq("R1 device byte 2", 32'(dev_log[2]), 32'h33);
    rd(3'd0, v); chk_eq("R5 source incremented", v, 32'h13);
    rd(3'd1, v); chk_eq("R5 destination fixed", v, DEV);
    rd(3'd2, v); chk_eq("R6 count zero at end", v, 0);
    rd(3'd4, v); chk_eq("R7 done set", v, 1);
    chk_eq("R8 irq raised", 32'(irq), 1);
    pulse(); repeat (4) @(negedge clk);
    chk_eq("R2 zero count ignores request", 32'(dev_n), 3);
    wr(3'd4, 1);
    @(negedge clk); chk_eq("R8 irq cleared with done", 32'(irq), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(3'd2, 2); wr(3'd3, 32'h46);
    pulse(); repeat (4) @(negedge clk);
    rd(3'd4, v); chk_eq("R2 disabled not busy", v, 0);
    rd(3'd2, v); chk_eq("R2 disabled count kept", v, 2);
    chk_eq("R2 disabled no bus write", 32'(dev_n), 3);
  endtask

  task automatic t_cont_d2m();
    logic [31:0] v;
    dev_rd = 0; lat = 2;
    wr(3'd0, DEV); wr(3'd1, 32'h40); wr(3'd2, 6); wr(3'd3, 32'h39);
    pulse(); wait_idle();
    for (int i = 0; i < 3; i++) begin
      chk_eq("R4 memory low byte", 32'(mem[8'h40 + 8'(2*i)]), 32'(i));
      chk_eq("R4 memory high byte", 32'(mem[8'h41 + 8'(2*i)]), 32'hB0);
    end
    rd(3'd1, v); chk_eq("R5 halfword destination step", v, 32'h46);
    rd(3'd0, v); chk_eq("R5 source fixed", v, DEV);
    rd(3'd2, v); chk_eq("R6 halfword count zero", v, 0);
    rd(3'd4, v); chk_eq("R7 continuous done", v, 1);
    chk_eq("R8 no irq when disabled", 32'(irq), 0);
    wr(3'd4, 1);
  endtask

  task automatic t_mixed();
    logic [31:0] v;
    lat = 0;
    mem[8'h60] = 8'h5A; mem[8'h61] = 8'hC3; mem[8'h62] = 8'h77; mem[8'h63] = 8'h88;
    wr(3'd0, 32'h60); wr(3'd1, 32'h80); wr(3'd2, 2); wr(3'd3, 32'h1D);
    pulse(); wait_idle();
    chk_eq("R1 half to byte 0", 32'(mem[8'h80]), 32'h5A);
    chk_eq("R1 half to byte 1", 32'(mem[8'h81]), 32'h77);
    rd(3'd0, v); chk_eq("R5 source half step", v, 32'h64);
    rd(3'd1, v); chk_eq("R5 destination byte step", v, 32'h82);
    wr(3'd4, 1);
    mem[8'h90] = 8'h3C; mem[8'h91] = 8'h4D;
    wr(3'd0, 32'h90); wr(3'd1, 32'hA0); wr(3'd2, 3); wr(3'd3, 32'h2D);
    pulse(); wait_idle();
    chk_eq("R1 zero-extended byte", 32'({mem[8'hA1], mem[8'hA0]}), 32'h003C);
    chk_eq("R1 zero-extended byte 2", 32'({mem[8'hA3], mem[8'hA2]}), 32'h004D);
    rd(3'd2, v); chk_eq("R6 odd count saturates", v, 0);
    wr(3'd4, 1);
  endtask

  task automatic t_abort_and_busy();
    logic [31:0] v;
    manual = 1; force_ack = 0;
    wr(3'd0, 32'h10); wr(3'd1, DEV); wr(3'd2, 4); wr(3'd3, 32'h47);
    pulse();
    rd(3'd4, v); chk_eq("R7 busy while waiting", v, 2);
    wr(3'd0, 32'h55);
    rd(3'd0, v); chk_eq("R10 source write ignored when busy", v, 32'h10);
    wr(3'd2, 9);
    rd(3'd2, v); chk_eq("R10 count write ignored when busy", v, 4);
    chk_eq("R1 read phase address", bus_addr, 32'h10);
    wr(3'd4, 1);
    rd(3'd4, v); chk_eq("R9 abort idles", v, 0);
    chk_eq("R9 abort drops bus", 32'(bus_valid), 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(3'd2, 1);
    pulse();
    force_ack = 1; @(negedge clk); force_ack = 0;
    chk_eq("R1 write phase after read", 32'(bus_we), 1);
    force_ack = 1; reg_wr = 1; reg_addr = 3'd4; reg_wdata = 1;
    @(negedge clk); force_ack = 0; reg_wr = 0;
    rd(3'd4, v); chk_eq("R9 abort wins over final ack", v, 0);
    chk_eq("R9 no irq after collision", 32'(irq), 0);
    rd(3'd2, v); chk_eq("R9 count not updated", v, 1);
    pulse();
    force_ack = 1; @(negedge clk); force_ack = 0;
    rd(3'd4, v); chk_eq("R7 busy in write phase", v, 2);
    force_ack = 1; @(negedge clk); force_ack = 0;
    rd(3'd4, v); chk_eq("R7 done on final ack", v, 1);
    chk_eq("R8 irq on completion", 32'(irq), 1);
    rd(3'd2, v); chk_eq("R6 count zero after ack", v, 0);
    manual = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_steal_m2d();
    t_disabled();
    t_cont_d2m();
    t_mixed();
    t_abort_and_busy();
    t_collision();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule